// File: doc/BRIEF.md
# UART Line Status and Interrupt Controller

This block forms the line status byte, the interrupt identification byte and the interrupt request for one channel of a 16550-style UART that has 16-entry FIFOs. It does not hold the FIFOs. The FIFOs report their occupancy counts to it. The receive path also strobes each character as it enters the receive FIFO, together with that character's error flags. The CPU-side decoder passes on the read and write strobes for the holding registers and the status registers.

The block keeps a small shadow of the error flags for each receive slot, so that it can show the flags of the character at the head of the FIFO. From the same shadow it also shows whether any stored character is bad. The receive-ready source is a level compared against the selected trigger threshold. The transmit-empty source is a latched event. With every enable cleared, the request line stays low while the status byte keeps updating, which gives polled operation.

Top module: `uart_stat_irq`

## Requirements
- R1: `lsr_o[0]` (data ready) is 1 exactly while `rx_count` is nonzero.
- R2: `lsr_o[1]` (overrun) sets in the cycle after an `rx_overrun` strobe and clears in the cycle after an `lsr_rd` strobe. When both strobes occur in the same cycle, the set wins.
- R3: `lsr_o[4:2]` shows the {break, framing, parity} flags of the character at the head of the receive FIFO, and is 0 when the FIFO is empty. `lsr_o[7]` is 1 while any stored character has a nonzero flag. A pop (`rhr_rd` with `rx_count` nonzero) drops the head. A push appends at position `rx_count` (or `rx_count`-1 when it coincides with a pop).
- R4: `lsr_o[5]` is 1 while `tx_count` is 0. `lsr_o[6]` is 1 only while `tx_count` is 0 and `tx_shift_idle` is 1.
- R5: Receive-ready is pending when `rx_count` is at or above the trigger level in FIFO mode (`trig_sel` 0,1,2,3 select 1,4,8,14). In single-register mode (`fifo_en`=0) it is pending when `rx_count` is nonzero.
- R6: The transmit-empty latch sets at a clock edge where `tx_count` is 0 and was nonzero at the previous edge. It clears on `thr_wr`, or on `isr_rd` while `isr_o` reports transmit-empty. A clear takes precedence over a set.
- R7: `isr_o[3:0]` reports the highest enabled pending source: 0x6 for line status (overrun or any head flag, enabled by `ier_en[2]`), 0x4 for receive-ready (`ier_en[0]`), 0x2 for transmit-empty (`ier_en[1]`), and 0x1 when none is pending. `isr_o[5:4]` are 0 and `isr_o[7:6]` both equal `fifo_en`.
- R8: `irq_o` is 1 exactly when `isr_o[0]` is 0. With `ier_en` all zero it stays 0, while `lsr_o` keeps updating.
- R9: After asynchronous reset, with `fifo_en`=0 and idle inputs, `lsr_o`=0x60, `isr_o`=0x01 and `irq_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | FIFO mode when 1, single holding register when 0 |
| ier_en | input | 3 | Enables: [0] receive-ready, [1] transmit-empty, [2] line status |
| trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | CW | Receive FIFO occupancy |
| rx_push | input | 1 | Character moved into receive FIFO |
| rx_push_pe | input | 1 | Parity error of pushed character |
| rx_push_fe | input | 1 | Framing error of pushed character |
| rx_push_bi | input | 1 | Break flag of pushed character |
| rx_overrun | input | 1 | Overrun event strobe |
| rhr_rd | input | 1 | CPU read of receive holding register |
| tx_count | input | CW | Transmit FIFO occupancy |
| tx_shift_idle | input | 1 | Transmit shift register empty |
| thr_wr | input | 1 | CPU write of transmit holding register |
| lsr_rd | input | 1 | CPU read of line status |
| isr_rd | input | 1 | CPU read of interrupt identification |
| lsr_o | output | 8 | Line status byte |
| isr_o | output | 8 | Interrupt identification byte |
| irq_o | output | 1 | Interrupt request |

## Verification
A corrupted error-shadow slot surfaces on `lsr_o[4:2]` only once that slot reaches the head, which may take many pops. It surfaces on `lsr_o[7]` in the very next cycle. A stuck or missed transmit-empty latch shows on `isr_o` and `irq_o` in the cycle after the edge, but only while the transmit enable is set and no higher source masks it. For that reason the stimulus spends phases with only that enable active. The reference model compares every output on every cycle, so a divergence is reported in the cycle it first becomes visible.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int FLAG_W = 3;  // {break, framing, parity}

  typedef enum logic [3:0] {
    ISR_NONE  = 4'h1,
    ISR_TXE   = 4'h2,
    ISR_RXRDY = 4'h4,
    ISR_LINE  = 4'h6
  } isr_code_e;

  // Receive trigger threshold in bytes for each selector value.
  function automatic logic [7:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'd1;
      2'd1:    return 8'd4;
      2'd2:    return 8'd8;
      default: return 8'd14;
    endcase
  endfunction

  // Encoded ISR low nibble from enabled pending sources, highest first.
  function automatic isr_code_e pick_source(input logic line_p, input logic rx_p,
                                            input logic tx_p);
    if (line_p)    return ISR_LINE;
    else if (rx_p) return ISR_RXRDY;
    else if (tx_p) return ISR_TXE;
    else           return ISR_NONE;
  endfunction
endpackage

// File: rtl/uart_rx_errq.sv
module uart_rx_errq
  import uart_stat_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     rx_count,
  input  logic              push,
  input  logic [FLAG_W-1:0] push_flags,
  input  logic              pop,
  output logic [FLAG_W-1:0] head_flags,
  output logic              any_err
);
  logic [FLAG_W-1:0] slot_q [DEPTH];
  logic [FLAG_W-1:0] slot_d [DEPTH];
  logic              do_pop;
  logic [CW-1:0]     ins_idx;

  assign do_pop  = pop && (rx_count != '0);
  assign ins_idx = do_pop ? rx_count - 1'b1 : rx_count;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) slot_d[i] = slot_q[i];
    if (do_pop) begin
      for (int i = 0; i < DEPTH - 1; i++) slot_d[i] = slot_q[i + 1];
      slot_d[DEPTH-1] = '0;
    end
    if (push) begin
      for (int i = 0; i < DEPTH; i++)
        if (ins_idx == CW'(i)) slot_d[i] = push_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
    end
  end

  assign head_flags = (rx_count != '0) ? slot_q[0] : '0;

  always_comb begin
    any_err = 1'b0;
    for (int i = 0; i < DEPTH; i++) any_err = any_err | (|slot_q[i]);
  end
endmodule

// File: rtl/uart_tx_evt.sv
module uart_tx_evt #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tx_count,
  input  logic          thr_wr,
  input  logic          isr_rd,
  input  logic          isr_shows_tx,
  output logic          pend,
  output logic          empty_evt
);
  logic prev_nz_q;
  logic clr;

  assign empty_evt = prev_nz_q && (tx_count == '0);
  assign clr       = thr_wr || (isr_rd && isr_shows_tx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_nz_q <= 1'b0;
      pend      <= 1'b0;
    end else begin
      prev_nz_q <= (tx_count != '0);
      if (clr)            pend <= 1'b0;
      else if (empty_evt) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_int_prio.sv
module uart_int_prio
  import uart_stat_pkg::*;
(
  input  logic       fifo_en,
  input  logic [2:0] ier_en,
  input  logic       line_pend,
  input  logic       rx_pend,
  input  logic       tx_pend,
  output logic [7:0] isr,
  output logic       irq
);
  isr_code_e code;

  assign code = pick_source(line_pend && ier_en[2], rx_pend && ier_en[0],
                            tx_pend && ier_en[1]);
  assign isr  = {fifo_en, fifo_en, 2'b00, code};
  assign irq  = (code != ISR_NONE);
endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq
  import uart_stat_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [2:0]    ier_en,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] rx_count,
  input  logic          rx_push,
  input  logic          rx_push_pe,
  input  logic          rx_push_fe,
  input  logic          rx_push_bi,
  input  logic          rx_overrun,
  input  logic          rhr_rd,
  input  logic [CW-1:0] tx_count,
  input  logic          tx_shift_idle,
  input  logic          thr_wr,
  input  logic          lsr_rd,
  input  logic          isr_rd,
  output logic [7:0]    lsr_o,
  output logic [7:0]    isr_o,
  output logic          irq_o
);
  logic [FLAG_W-1:0] head_flags;
  logic              any_err;
  logic              ovr_q;
  logic              rx_pend;
  logic              line_pend;
  logic              thre_pend;
  logic              tx_empty_evt;
  logic              isr_shows_tx;

  uart_rx_errq #(.DEPTH(DEPTH), .CW(CW)) u_errq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_count   (rx_count),
    .push       (rx_push),
    .push_flags ({rx_push_bi, rx_push_fe, rx_push_pe}),
    .pop        (rhr_rd),
    .head_flags (head_flags),
    .any_err    (any_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovr_q <= 1'b0;
    else if (rx_overrun) ovr_q <= 1'b1;
    else if (lsr_rd)     ovr_q <= 1'b0;
  end

  assign rx_pend   = fifo_en ? (8'(rx_count) >= trig_level(trig_sel))
                             : (rx_count != '0);
  assign line_pend = ovr_q || (|head_flags);

  assign isr_shows_tx = (isr_o[3:0] == ISR_TXE);

  uart_tx_evt #(.CW(CW)) u_txevt (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_count     (tx_count),
    .thr_wr       (thr_wr),
    .isr_rd       (isr_rd),
    .isr_shows_tx (isr_shows_tx),
    .pend         (thre_pend),
    .empty_evt    (tx_empty_evt)
  );

  uart_int_prio u_prio (
    .fifo_en   (fifo_en),
    .ier_en    (ier_en),
    .line_pend (line_pend),
    .rx_pend   (rx_pend),
    .tx_pend   (thre_pend),
    .isr       (isr_o),
    .irq       (irq_o)
  );

  assign lsr_o = {any_err,
                  (tx_count == '0) && tx_shift_idle,
                  (tx_count == '0),
                  head_flags,
                  ovr_q,
                  (rx_count != '0)};
endmodule

// File: rtl/uart_stat_irq_chk.sv
module uart_stat_irq_chk
  import uart_stat_pkg::*;
#(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic [2:0]    ier_en,
  input logic [1:0]    trig_sel,
  input logic [CW-1:0] rx_count,
  input logic          rx_overrun,
  input logic          lsr_rd,
  input logic          thr_wr,
  input logic          tx_empty_evt,
  input logic          thre_pend,
  input logic [7:0]    lsr_o,
  input logic [7:0]    isr_o,
  input logic          irq_o
);
  assert_ovr_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> lsr_o[1]);
  assert_ovr_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rx_overrun) |=> !lsr_o[1]);
  assert_temt_needs_thre_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_o[6] |-> lsr_o[5]);
  assert_below_trig_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && ier_en == 3'b001 && 8'(rx_count) < trig_level(trig_sel)) |-> !irq_o);
  assert_thr_wr_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !thre_pend);
  assert_empty_evt_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty_evt && !thr_wr && !$isunknown(isr_o)) |=> (thre_pend || $past(isr_o[3:0] == ISR_TXE)));
  assert_mode_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    isr_o[7:4] == {fifo_en, fifo_en, 2'b00});
  assert_irq_vs_isr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == !isr_o[0]);
  assert_polled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_en == 3'b000) |-> (!irq_o && isr_o[3:0] == ISR_NONE));
endmodule

bind uart_stat_irq uart_stat_irq_chk #(.CW(CW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_en      (fifo_en),
  .ier_en       (ier_en),
  .trig_sel     (trig_sel),
  .rx_count     (rx_count),
  .rx_overrun   (rx_overrun),
  .lsr_rd       (lsr_rd),
  .thr_wr       (thr_wr),
  .tx_empty_evt (tx_empty_evt),
  .thre_pend    (thre_pend),
  .lsr_o        (lsr_o),
  .isr_o        (isr_o),
  .irq_o        (irq_o)
);

// File: tb/uart_stat_irq_tb_top.sv
module uart_stat_irq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int CW         = 5;
  localparam int PHASE_LEN  = 400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fifo_en = 1'b0;
  logic [2:0]    ier_en = '0;
  logic [1:0]    trig_sel = '0;
  logic [CW-1:0] rx_count = '0;
  logic          rx_push = 1'b0, rx_push_pe = 1'b0, rx_push_fe = 1'b0, rx_push_bi = 1'b0;
  logic          rx_overrun = 1'b0, rhr_rd = 1'b0;
  logic [CW-1:0] tx_count = '0;
  logic          tx_shift_idle = 1'b1;
  logic          thr_wr = 1'b0, lsr_rd = 1'b0, isr_rd = 1'b0;
  logic [7:0]    lsr_o, isr_o;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;

  // Reference model state
  logic [2:0] rq[$];
  bit         m_ovr = 0;
  bit         m_thre = 0;
  bit         m_prev_nz = 0;
  int         m_tx = 0;
  bit         drv_dec = 0;
  logic [3:0] last_code = 4'h1;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_stat_irq #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  function automatic int lvl(input logic [1:0] s);
    int t[4] = '{1, 4, 8, 14};
    return t[s];
  endfunction

  // Advance the model over the clock edge that just used the held inputs.
  task automatic model_step();
    bit set_e, clr_e;
    set_e = m_prev_nz && (m_tx == 0);
    clr_e = thr_wr || (isr_rd && last_code == 4'h2);
    m_prev_nz = (m_tx != 0);
    if (clr_e) m_thre = 0;
    else if (set_e) m_thre = 1;
    if (rx_overrun) m_ovr = 1;
    else if (lsr_rd) m_ovr = 0;
    if (rhr_rd && rq.size() > 0) void'(rq.pop_front());
    if (rx_push && rq.size() < DEPTH) rq.push_back({rx_push_bi, rx_push_fe, rx_push_pe});
    m_tx = m_tx + (thr_wr ? 1 : 0) - (drv_dec ? 1 : 0);
  endtask

  task automatic compare();
    logic [2:0] head;
    logic any;
    bit rxp, lsp;
    logic [3:0] code;
    logic [7:0] exp_lsr;
    head = (rq.size() > 0) ? rq[0] : 3'b000;
    any = 1'b0;
    foreach (rq[i]) any |= (|rq[i]);
    rxp = fifo_en ? (rq.size() >= lvl(trig_sel)) : (rq.size() > 0);
    lsp = m_ovr || (head != 0);
    if (ier_en[2] && lsp) code = 4'h6;
    else if (ier_en[0] && rxp) code = 4'h4;
    else if (ier_en[1] && m_thre) code = 4'h2;
    else code = 4'h1;
    exp_lsr = {any, (m_tx == 0) && tx_shift_idle, m_tx == 0, head, m_ovr, rq.size() > 0};
    chk("R1 data ready", {7'd0, lsr_o[0]}, {7'd0, exp_lsr[0]});
    chk("R2 overrun", {7'd0, lsr_o[1]}, {7'd0, exp_lsr[1]});
    chk("R3 error flags", {lsr_o[7], 4'd0, lsr_o[4:2]}, {exp_lsr[7], 4'd0, exp_lsr[4:2]});
    chk("R4 tx empty bits", {6'd0, lsr_o[6:5]}, {6'd0, exp_lsr[6:5]});
    if (code == 4'h4)      chk("R5 rx ready isr", isr_o, {fifo_en, fifo_en, 2'b00, code});
    else if (code == 4'h2) chk("R6 tx empty isr", isr_o, {fifo_en, fifo_en, 2'b00, code});
    else                   chk("R7 isr", isr_o, {fifo_en, fifo_en, 2'b00, code});
    chk("R8 irq", {7'd0, irq_o}, {7'd0, code != 4'h1});
    last_code = code;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(7));
    #(CLK_PERIOD * 2 + 1);
    // R9: reset values while still in reset
    chk("R9 reset lsr", lsr_o, 8'h60);
    chk("R9 reset isr", isr_o, 8'h01);
    chk("R9 reset irq", {7'd0, irq_o}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    for (int ph = 0; ph < 8; ph++) begin
      for (int c = 0; c < PHASE_LEN; c++) begin
        @(negedge clk);
        model_step();
        if (c == 0) begin
          fifo_en  = (ph != 3) && (ph != 7);
          trig_sel = 2'(ph);
          case (ph)
            1: ier_en = 3'b000;        // polled mode, R8
            2: ier_en = 3'b010;        // transmit-empty only, R6
            4: ier_en = 3'b001;        // receive-ready only, R5
            default: ier_en = 3'(ph);
          endcase
          if (ph == 6) ier_en = 3'b111;
        end
        begin
          int r;
          bit push_bias;
          push_bias = (ph % 2 == 0);
          r = $urandom_range(0, 99);
          rx_push = push_bias ? (r < 45) : (r < 20);
          r = $urandom_range(0, 99);
          rx_push_pe = (r < 6); rx_push_fe = (r >= 6 && r < 10); rx_push_bi = (r == 10);
          r = $urandom_range(0, 99);
          rhr_rd = push_bias ? (r < 20) : (r < 45);
          rx_overrun = ($urandom_range(0, 99) < 2);
          lsr_rd = ($urandom_range(0, 99) < 8);
          isr_rd = ($urandom_range(0, 99) < 10);
          r = $urandom_range(0, 99);
          thr_wr  = (r < 12) && (m_tx < 15);
          drv_dec = (r >= 70) && (m_tx > 0);
          tx_shift_idle = (m_tx == 0) ? ($urandom_range(0, 1) == 1) : 1'b0;
          rx_count = CW'(rq.size());
          tx_count = CW'(m_tx);
        end
        #1;
        compare();
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule